// File: doc/BRIEF.md
# Ling-Carry Parallel-Prefix Adder

This block adds two unsigned N-bit operands and a carry-in, producing an N-bit sum and a carry-out. It never builds true carries in its prefix network. A pre-processing stage forms, for each bit, a generate (AND), an inclusive-OR propagate and a half-sum (XOR). A Kogge-Stone style tree then combines these terms into Ling pseudo-carries. The tree uses black cells, which produce both group terms, and gray cells, which produce only the group generate once a span reaches bit zero. A sum stage restores the true carry and forms each sum bit.

The pseudo-carry into the prefix at bit i obeys H(i) = g(i) | t(i-1)·H(i-1). The carry-in is merged into the generate of bit zero, so H(0) = g(0) | cin. This keeps the tree at log2(N) levels. The true carry out of bit i is t(i)·H(i). Each sum bit i ≥ 1 is taken from a two-way select: when H(i-1) is set it outputs half-sum(i) XOR t(i-1), and otherwise it outputs half-sum(i). This keeps an AND level off the path between tree output and sum.

The adder logic is combinational. A parameter places an optional register on the outputs so that timing can be checked from one register to the next. The width is a parameter, with 16 bits as the default and 8 and 32 bits as supported alternatives.

Top module: `ling_prefix_adder`

## Requirements
- R1: sum_o equals the low WIDTH bits of a_i + b_i + cin_i, taking all three as unsigned values.
- R2: cout_o equals bit WIDTH (the carry out of the most significant bit) of a_i + b_i + cin_i. For example, 0xFFFF + 0xFFFF + 1 gives sum 0xFFFF and carry 1 at 16 bits.
- R3: The carry-in enters only at bit 0. With both operands zero and cin_i = 1, the result is sum 1 and carry 0, and sum_o[0] always equals a_i[0] ^ b_i[0] ^ cin_i.
- R4: With REG_OUT = 1, sum_o and cout_o show the result for the inputs present at a rising clk edge from just after that edge onward. While rst_n is low they read zero. With REG_OUT = 0 the outputs follow the inputs combinationally.
- R5: Setting WIDTH to 8, 16 or 32 gives the R1 and R2 behaviour at that width. At 8 bits this holds for every operand pair and both carry-in values.
- R6: When a_i ^ b_i is all ones, so that every bit propagates, sum_o is all copies of ~cin_i and cout_o equals cin_i. Examples are 0xAAAA + 0x5555 and 0xFFFF + 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register and for the assertions |
| rst_n | input | 1 | Active-low reset that clears the output register |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum, registered when REG_OUT = 1 |
| cout_o | output | 1 | Carry out of the top bit, registered when REG_OUT = 1 |

## Verification
On every cycle, the assertions compare the output against the arithmetic sum with the one-edge latency applied. They also check each tree output against the pseudo-carry recurrence, using the pre-stage terms, and check that the carry-in is merged into the bit-zero generate. Further assertions cover the all-propagate pattern and the cleared outputs after reset. Only the bench's scenarios can show that the alternate widths work. These scenarios cover every 8-bit operand pair and carry-in, and they force the carry to ripple through the full width at 16 and 32 bits. They also place the expected result at exactly the edge that the registered mode requires.

// File: rtl/ling_pkg.sv
package ling_pkg;

    typedef enum logic [1:0] {
        CELL_PASS,
        CELL_GRAY,
        CELL_BLACK
    } cell_kind_e;

    // Number of Kogge-Stone levels for a given operand width.
    function automatic int ks_levels(input int width);
        return (width < 2) ? 1 : $clog2(width);
    endfunction

    // Node at position pos, combining with pos-span:
    // below span nothing to combine, below 2*span the lower span is complete.
    function automatic cell_kind_e cell_kind(input int pos, input int span);
        if (pos < span)
            return CELL_PASS;
        else if (pos < 2 * span)
            return CELL_GRAY;
        else
            return CELL_BLACK;
    endfunction

endpackage

// File: rtl/ling_pre_stage.sv
module ling_pre_stage #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] gen_o,
    output logic [WIDTH-1:0] tor_o,
    output logic [WIDTH-1:0] hsum_o,
    output logic [WIDTH-1:0] leaf_gen_o,
    output logic [WIDTH-1:0] leaf_prop_o
);

    assign gen_o  = a_i & b_i;
    assign tor_o  = a_i | b_i;
    assign hsum_o = a_i ^ b_i;

    // Carry-in acts as a generate one position below bit 0; merging it here
    // keeps the tree at ks_levels(WIDTH) levels.
    assign leaf_gen_o[0]  = gen_o[0] | cin_i;
    assign leaf_prop_o[0] = 1'b0;

    // Ling leaves: propagate of position i is the OR-propagate of bit i-1.
    assign leaf_gen_o[WIDTH-1:1]  = gen_o[WIDTH-1:1];
    assign leaf_prop_o[WIDTH-1:1] = tor_o[WIDTH-2:0];

endmodule

// File: rtl/ling_prefix_cells.sv
module ling_black_cell (
    input  logic hi_gen,
    input  logic hi_prop,
    input  logic lo_gen,
    input  logic lo_prop,
    output logic out_gen,
    output logic out_prop
);
    assign out_gen  = hi_gen | (hi_prop & lo_gen);
    assign out_prop = hi_prop & lo_prop;
endmodule

module ling_gray_cell (
    input  logic hi_gen,
    input  logic hi_prop,
    input  logic lo_gen,
    output logic out_gen
);
    assign out_gen = hi_gen | (hi_prop & lo_gen);
endmodule

// File: rtl/ling_kogge_tree.sv
module ling_kogge_tree #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] leaf_gen_i,
    input  logic [WIDTH-1:0] leaf_prop_i,
    output logic [WIDTH-1:0] hcar_o
);

    localparam int LEVELS = ling_pkg::ks_levels(WIDTH);

    logic [LEVELS:0][WIDTH-1:0] gen_lvl;
    logic [LEVELS:0][WIDTH-1:0] prop_lvl;
    logic                       unused_prop;

    assign gen_lvl[0]  = leaf_gen_i;
    assign prop_lvl[0] = leaf_prop_i;

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int SPAN = 1 << l;
        for (genvar i = 0; i < WIDTH; i++) begin : g_pos
            if (ling_pkg::cell_kind(i, SPAN) == ling_pkg::CELL_PASS) begin : g_pass
                assign gen_lvl[l+1][i]  = gen_lvl[l][i];
                assign prop_lvl[l+1][i] = prop_lvl[l][i];
            end else if (ling_pkg::cell_kind(i, SPAN) == ling_pkg::CELL_GRAY) begin : g_gray
                ling_gray_cell u_gray (
                    .hi_gen  (gen_lvl[l][i]),
                    .hi_prop (prop_lvl[l][i]),
                    .lo_gen  (gen_lvl[l][i-SPAN]),
                    .out_gen (gen_lvl[l+1][i])
                );
                assign prop_lvl[l+1][i] = 1'b0;
            end else begin : g_black
                ling_black_cell u_black (
                    .hi_gen   (gen_lvl[l][i]),
                    .hi_prop  (prop_lvl[l][i]),
                    .lo_gen   (gen_lvl[l][i-SPAN]),
                    .lo_prop  (prop_lvl[l][i-SPAN]),
                    .out_gen  (gen_lvl[l+1][i]),
                    .out_prop (prop_lvl[l+1][i])
                );
            end
        end
    end

    assign hcar_o      = gen_lvl[LEVELS];
    assign unused_prop = ^prop_lvl;

endmodule

// File: rtl/ling_sum_stage.sv
module ling_sum_stage #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] hsum_i,
    input  logic [WIDTH-1:0] tor_i,
    input  logic [WIDTH-1:0] hcar_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    assign sum_o[0] = hsum_i[0] ^ cin_i;

    // Pseudo-carry selects; the AND with tor is absorbed into the mux leg.
    for (genvar i = 1; i < WIDTH; i++) begin : g_bit
        assign sum_o[i] = hcar_i[i-1] ? (hsum_i[i] ^ tor_i[i-1]) : hsum_i[i];
    end

    assign cout_o = tor_i[WIDTH-1] & hcar_i[WIDTH-1];

endmodule

// File: rtl/ling_prefix_adder.sv
module ling_prefix_adder #(
    parameter int WIDTH   = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    localparam int SUM_W = WIDTH + 1;

    logic [WIDTH-1:0] gen_bit;
    logic [WIDTH-1:0] tor_bit;
    logic [WIDTH-1:0] hsum_bit;
    logic [WIDTH-1:0] leaf_gen;
    logic [WIDTH-1:0] leaf_prop;
    logic [WIDTH-1:0] hcar;
    logic [WIDTH-1:0] sum_c;
    logic             cout_c;

    ling_pre_stage #(.WIDTH(WIDTH)) u_pre (
        .a_i         (a_i),
        .b_i         (b_i),
        .cin_i       (cin_i),
        .gen_o       (gen_bit),
        .tor_o       (tor_bit),
        .hsum_o      (hsum_bit),
        .leaf_gen_o  (leaf_gen),
        .leaf_prop_o (leaf_prop)
    );

    ling_kogge_tree #(.WIDTH(WIDTH)) u_tree (
        .leaf_gen_i  (leaf_gen),
        .leaf_prop_i (leaf_prop),
        .hcar_o      (hcar)
    );

    // r1_ / r3_: tree output must follow the pseudo-carry recurrence.
    a_r3_cin_fold: assert property (@(posedge clk) disable iff (!rst_n)
        hcar[0] == (gen_bit[0] | cin_i));

    for (genvar k = 1; k < WIDTH; k++) begin : g_recur
        a_r1_ling_recur: assert property (@(posedge clk) disable iff (!rst_n)
            hcar[k] == (gen_bit[k] | (tor_bit[k-1] & hcar[k-1])));
    end

    ling_sum_stage #(.WIDTH(WIDTH)) u_sum (
        .hsum_i (hsum_bit),
        .tor_i  (tor_bit),
        .hcar_i (hcar),
        .cin_i  (cin_i),
        .sum_o  (sum_c),
        .cout_o (cout_c)
    );

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sum_o  <= '0;
                cout_o <= 1'b0;
            end else begin
                sum_o  <= sum_c;
                cout_o <= cout_c;
            end
        end

        a_r1_sum_value: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (sum_o == $past(sum_c)) &&
            ({cout_o, sum_o} == $past(SUM_W'(a_i) + SUM_W'(b_i) + SUM_W'(cin_i))));

        a_r2_carry_out: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> cout_o == $past((SUM_W'(a_i) + SUM_W'(b_i) + SUM_W'(cin_i)) >> WIDTH));

        a_r4_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!rst_n) |-> (sum_o == '0) && !cout_o);

        a_r6_all_prop: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(&(a_i ^ b_i))) |->
            (sum_o == {WIDTH{~$past(cin_i)}}) && (cout_o == $past(cin_i)));
    end else begin : g_comb
        assign sum_o  = sum_c;
        assign cout_o = cout_c;

        a_r1_sum_value: assert property (@(posedge clk) disable iff (!rst_n)
            {cout_o, sum_o} == SUM_W'(a_i) + SUM_W'(b_i) + SUM_W'(cin_i));

        a_r6_all_prop: assert property (@(posedge clk) disable iff (!rst_n)
            (&(a_i ^ b_i)) |-> (sum_o == {WIDTH{~cin_i}}) && (cout_o == cin_i));
    end

endmodule

// File: tb/test_ling_prefix_adder.sv
module test_ling_prefix_adder;

    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [W-1:0] a, b, sum;
    logic         cin, cout;
    logic [7:0]   a8, b8, sum8;
    logic         cin8, cout8;
    logic [31:0]  a32, b32, sum32;
    logic         cin32, cout32;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [W:0] exp_q[$];
    string      req_q[$];
    logic       drv_vld = 1'b0;
    logic       mon_v;
    logic [W:0] mon_e;
    string      mon_r;

    ling_prefix_adder #(.WIDTH(W), .REG_OUT(1'b1)) i_ling_prefix_adder (
        .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .cin_i(cin),
        .sum_o(sum), .cout_o(cout)
    );

    ling_prefix_adder #(.WIDTH(8), .REG_OUT(1'b0)) i_ling_prefix_adder_w8 (
        .clk(clk), .rst_n(rst_n), .a_i(a8), .b_i(b8), .cin_i(cin8),
        .sum_o(sum8), .cout_o(cout8)
    );

    ling_prefix_adder #(.WIDTH(32), .REG_OUT(1'b0)) i_ling_prefix_adder_w32 (
        .clk(clk), .rst_n(rst_n), .a_i(a32), .b_i(b32), .cin_i(cin32),
        .sum_o(sum32), .cout_o(cout32)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: present operands at a falling edge and queue the expected result.
    task automatic drive16(input logic [W-1:0] x, input logic [W-1:0] y,
                           input logic c, input string req);
        @(negedge clk);
        a = x; b = y; cin = c; drv_vld = 1'b1;
        exp_q.push_back({1'b0, x} + {1'b0, y} + {{W{1'b0}}, c});
        req_q.push_back(req);
    endtask

    task automatic drive32(input logic [31:0] x, input logic [31:0] y,
                           input logic c, input string req);
        logic [32:0] e;
        @(negedge clk);
        a32 = x; b32 = y; cin32 = c;
        e = {1'b0, x} + {1'b0, y} + {32'b0, c};
        #2;
        chk(req, 64'({cout32, sum32}), 64'(e));
    endtask

    // Monitor: the registered result for an edge is visible just after it (R4).
    always begin
        @(posedge clk);
        mon_v = drv_vld;
        #2;
        if (mon_v) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R4 result with empty queue actual %h expected none", {cout, sum});
            end else begin
                mon_e = exp_q.pop_front();
                mon_r = req_q.pop_front();
                chk(mon_r, 64'({cout, sum}), 64'(mon_e));
            end
        end
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        a = 16'h1234; b = 16'h4321; cin = 1'b1;
        a8 = '0; b8 = '0; cin8 = 1'b0;
        a32 = '0; b32 = '0; cin32 = 1'b0;

        // R4: outputs cleared while reset is held, despite nonzero operands
        repeat (3) @(posedge clk);
        #2;
        chk("R4 reset clear", 64'({cout, sum}), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        drive16(16'h0000, 16'h0000, 1'b0, "R1 zero");
        drive16(16'h0000, 16'h0000, 1'b1, "R3 cin only");
        drive16(16'h0001, 16'h0000, 1'b1, "R3 lsb carry");
        drive16(16'h0001, 16'h0001, 1'b0, "R3 lsb generate");
        drive16(16'hFFFF, 16'h0000, 1'b1, "R6 ones plus cin");
        drive16(16'hFFFF, 16'h0000, 1'b0, "R6 ones no cin");
        drive16(16'hAAAA, 16'h5555, 1'b0, "R6 alternating");
        drive16(16'h5555, 16'hAAAA, 1'b1, "R6 alternating cin");
        drive16(16'hFFFF, 16'hFFFF, 1'b1, "R2 max");
        drive16(16'h8000, 16'h8000, 1'b0, "R2 top generate");
        drive16(16'h7FFF, 16'h0001, 1'b0, "R1 long ripple");
        for (int n = 0; n < 1500; n++) begin
            drive16(16'($urandom), 16'($urandom), 1'($urandom), "R1 R2 random");
        end
        @(negedge clk);
        drv_vld = 1'b0;
        wait (exp_q.size() == 0);

        // R5: every 8-bit operand pair and carry-in
        for (int ia = 0; ia < 256; ia++) begin
            for (int ib = 0; ib < 256; ib++) begin
                for (int c = 0; c < 2; c++) begin
                    @(negedge clk);
                    a8 = 8'(ia); b8 = 8'(ib); cin8 = 1'(c);
                    #2;
                    chk("R5 width 8", 64'({cout8, sum8}), 64'(ia + ib + c));
                end
            end
        end

        // R5 / R6 at 32 bits
        drive32(32'hFFFF_FFFF, 32'h0000_0000, 1'b1, "R6 width 32 ones");
        drive32(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R6 width 32 alternating");
        drive32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R5 width 32 max");
        drive32(32'h0000_0000, 32'h0000_0000, 1'b1, "R3 width 32 cin");
        for (int n = 0; n < 1000; n++) begin
            drive32($urandom, $urandom, 1'($urandom), "R5 width 32 random");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule